// File: doc/BRIEF.md
# Folded Two-Half Synchronous Word Memory

This block is a synthesizable behavioural model of a 2-kbit synchronous memory that holds 128 words of 16 bits. The storage is split into two identical 1-kbit halves that are always accessed together. The low byte of every word lives in half 0 and the high byte in half 1. Each half is folded into a square of 32 rows by 32 columns, not stored as a tall 128 by 8 stack. One shared row decoder sits between the halves and drives a single word line into both of them. A 4:1 column-group selector in each half connects 8 of its 32 columns to that half's byte.

An external sequencer drives the timing through separate strobes. A cycle-start strobe latches the 7-bit address. Word-line enable together with write enable commits bus data into the array. Sense enable copies the addressed word into an output latch. Output enable places the latched word on the shared bidirectional data bus. Whenever the block is not presenting read data, it releases the bus.

Top module: `fsram_folded_top`

## Requirements
- R1: After reset the output latch holds 16'h0000, so asserting chip select and output enable before any sense shows 16'h0000 on the bus.
- R2: A word written at an address and later sensed at the same address reads back unchanged; bits 7:0 are stored in half 0 and bits 15:8 in half 1, and both halves are written and read in the same cycle.
- R3: The address is captured only on a clock edge where chip select and cycle start are both high. Address pin changes at any other time have no effect on the word that is written or sensed.
- R4: The array changes only on an edge where chip select, word-line enable and write enable are all high. Write enable without word-line enable, or word-line enable without write enable, leaves the stored word unchanged.
- R5: The block drives the data bus only while chip select and output enable are both high and write enable is low; otherwise the bus is high impedance.
- R6: The output latch loads only on an edge with chip select and sense enable high and write enable low; at all other times it keeps its value.
- R7: Address bits 6:2 select one of 32 rows and bits 1:0 select column group g. Group g of a half uses columns 8g to 8g+7, and data bit b uses column 8g+b, so the four words of a row and words in different rows are all independent.
- R8: With chip select low, no write takes place even if word-line enable and write enable are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every strobe is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel | input | 1 | Chip select; gates every strobe and the bus driver |
| cyc_start | input | 1 | Latches the address at the start of a cycle |
| addr | input | 7 | Word address: row in bits 6:2, column group in bits 1:0 |
| wl_en | input | 1 | Word-line enable strobe |
| wr_en | input | 1 | Write enable strobe |
| sense_en | input | 1 | Loads the addressed word into the output latch |
| out_en | input | 1 | Puts the output latch onto the data bus |
| data_io | inout | 16 | Shared bidirectional data bus |

## Verification
A corrupted latched address shows up as the wrong word on the bus during the next read. It can also show up as a write that lands in a neighbouring row or column group, which a later readback of that neighbour reveals. A wrong column mapping or a swapped half appears as bytes or groups that overwrite each other, and this is visible as soon as all four words of a row are read back. A stuck output latch or a bus driver that stays on shows on the bus in the same cycle in which output enable changes.

// File: rtl/fsram_pkg.sv
// Package fsram_pkg
// Shared geometry of the folded memory. Every width and count is derived
// from the word count, the word width and the column count of one half.
package fsram_pkg;
    localparam int WORDS   = 128;
    localparam int WORD_W  = 16;
    localparam int HALVES  = 2;
    localparam int HALF_W  = WORD_W / HALVES;
    localparam int COLS    = 32;
    localparam int GROUPS  = COLS / HALF_W;
    localparam int ROWS    = WORDS / GROUPS;
    localparam int ROW_AW  = $clog2(ROWS);
    localparam int GRP_AW  = $clog2(GROUPS);
    localparam int ADDR_W  = ROW_AW + GRP_AW;
endpackage

// File: rtl/fsram_addr_latch.sv
// Module fsram_addr_latch
// Holds the word address for the whole access. It loads only when the
// capture strobe is high. It assumes the sequencer raises capture once,
// at the start of each cycle.
module fsram_addr_latch #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);

    // Address register: cleared on reset, loaded on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_o <= '0;
        else if (capture_i) addr_o <= addr_i;
    end

    // R3: without a capture strobe the held address stays put
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !capture_i) |=> $stable(addr_o));

endmodule

// File: rtl/fsram_onehot_dec.sv
// Module fsram_onehot_dec
// Binary to one-hot decoder. The top uses one instance as the central row
// decoder, shared by both halves, and another as the column-group decoder.
module fsram_onehot_dec #(
    parameter int IW = 5,
    localparam int OW = 1 << IW
) (
    input  logic [IW-1:0] sel_i,
    output logic [OW-1:0] line_o
);

    // Raise exactly one output line per code value.
    always_comb begin
        line_o = '0;
        line_o[sel_i] = 1'b1;
    end

    // R7: a known select always yields a single active line
    always_comb begin
        if (!$isunknown(sel_i))
            a_r7_onehot: assert ($onehot(line_o));
    end

endmodule

// File: rtl/fsram_half.sv
// Module fsram_half
// One folded half of the memory: ROWS x COLS bits plus a column-group
// selector that maps one group of DW columns onto the half's data byte.
// It assumes the row and group selects are one-hot, and it has no reset of
// its own because the stored contents survive reset.
module fsram_half #(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    parameter int DW   = 8,
    localparam int GROUPS = COLS / DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROWS-1:0]   row_oh_i,
    input  logic [GROUPS-1:0] grp_oh_i,
    input  logic              wr_i,
    input  logic [DW-1:0]     wd_i,
    output logic [DW-1:0]     rd_o
);

    logic [ROWS-1:0][COLS-1:0] mem;
    logic [COLS-1:0]           row_word;
    logic [GROUPS-1:0][DW-1:0] grp_word;

    // Cell array write: data bit b goes to column DW*g+b of the selected row.
    always_ff @(posedge clk) begin
        if (wr_i) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int g = 0; g < GROUPS; g++) begin
                    if (row_oh_i[r] && grp_oh_i[g]) begin
                        for (int b = 0; b < DW; b++) begin
                            mem[r][g*DW+b] <= wd_i[b];
                        end
                    end
                end
            end
        end
    end

    // Word line read: OR together the rows, gated by the one-hot word line.
    always_comb begin
        row_word = '0;
        for (int r = 0; r < ROWS; r++) begin
            row_word = row_word | (mem[r] & {COLS{row_oh_i[r]}});
        end
    end

    // Split the selected row into its column groups.
    genvar gi;
    generate
        for (gi = 0; gi < GROUPS; gi++) begin : g_grp
            assign grp_word[gi] = row_word[gi*DW +: DW];
        end
    endgenerate

    // Column mux: pass the one group whose select line is high.
    always_comb begin
        rd_o = '0;
        for (int g = 0; g < GROUPS; g++) begin
            rd_o = rd_o | (grp_word[g] & {DW{grp_oh_i[g]}});
        end
    end

    // R4: the array holds still on any edge without a write strobe
    a_r4_array_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_i) |=> $stable(mem));

endmodule

// File: rtl/fsram_folded_top.sv
// Module fsram_folded_top
// 128 x 16 synchronous memory made of two folded 32x32 halves that share a
// central row decoder. It latches the address, gates the strobes, holds read
// data in an output latch and drives the bidirectional bus. It assumes an
// external sequencer orders the strobes within each cycle.
module fsram_folded_top (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chip_sel,
    input  logic        cyc_start,
    input  logic [6:0]  addr,
    input  logic        wl_en,
    input  logic        wr_en,
    input  logic        sense_en,
    input  logic        out_en,
    inout  tri   [15:0] data_io
);
    import fsram_pkg::*;

    logic [ADDR_W-1:0]            addr_q;
    logic [ROWS-1:0]              row_oh;
    logic [GROUPS-1:0]            grp_oh;
    logic                         wr_fire;
    logic                         sense_ld;
    logic                         drv_en;
    logic [HALVES-1:0][HALF_W-1:0] half_rd;
    logic [WORD_W-1:0]            rd_word;
    logic [WORD_W-1:0]            rd_q;

    // Strobe gating: every action needs chip select.
    assign wr_fire  = chip_sel & wl_en & wr_en;
    assign sense_ld = chip_sel & sense_en & ~wr_en;
    assign drv_en   = chip_sel & out_en & ~wr_en;

    fsram_addr_latch #(.AW(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (chip_sel & cyc_start),
        .addr_i    (addr),
        .addr_o    (addr_q)
    );

    fsram_onehot_dec #(.IW(ROW_AW)) u_row_dec (
        .sel_i  (addr_q[ADDR_W-1:GRP_AW]),
        .line_o (row_oh)
    );

    fsram_onehot_dec #(.IW(GRP_AW)) u_grp_dec (
        .sel_i  (addr_q[GRP_AW-1:0]),
        .line_o (grp_oh)
    );

    genvar hi;
    generate
        for (hi = 0; hi < HALVES; hi++) begin : g_half
            fsram_half #(.ROWS(ROWS), .COLS(COLS), .DW(HALF_W)) u_half (
                .clk      (clk),
                .rst_n    (rst_n),
                .row_oh_i (row_oh),
                .grp_oh_i (grp_oh),
                .wr_i     (wr_fire),
                .wd_i     (data_io[hi*HALF_W +: HALF_W]),
                .rd_o     (half_rd[hi])
            );
            assign rd_word[hi*HALF_W +: HALF_W] = half_rd[hi];
        end
    endgenerate

    // Output latch: cleared on reset, loaded by sense enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_q <= '0;
        else if (sense_ld) rd_q <= rd_word;
    end

    // Bus driver: present the latched word, otherwise release the bus.
    assign data_io = drv_en ? rd_q : {WORD_W{1'bz}};

    // R2: a sense edge captures the word the halves presented
    a_r2_sense_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sense_ld) |=> (rd_q == $past(rd_word)));

    // R6: without sense the output latch keeps its value
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !sense_ld) |=> $stable(rd_q));

endmodule

// File: tb/fsram_folded_top_tb.sv
// Directed bench for fsram_folded_top: one task per scenario.
module fsram_folded_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chip_sel, cyc_start, wl_en, wr_en, sense_en, out_en;
    logic [6:0]  addr;
    tri   [15:0] data_io;
    logic [15:0] tb_drv;
    logic        tb_en;

    int n_chk  = 0;
    int n_fail = 0;

    assign data_io = tb_en ? tb_drv : 16'hzzzz;

    fsram_folded_top u_dut (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .cyc_start(cyc_start),
        .addr(addr), .wl_en(wl_en), .wr_en(wr_en), .sense_en(sense_en),
        .out_en(out_en), .data_io(data_io)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        chip_sel = 0; cyc_start = 0; wl_en = 0; wr_en = 0;
        sense_en = 0; out_en = 0; tb_en = 0; tb_drv = '0;
    endtask

    // One access with chosen strobes; the address pins are scrambled after capture.
    task automatic strobe_write(input logic [6:0] a, input logic [15:0] d,
                                input logic cs, input logic wl, input logic we);
        @(negedge clk);
        chip_sel = 1; cyc_start = 1; addr = a;
        @(negedge clk);
        cyc_start = 0; addr = ~a; chip_sel = cs; wl_en = wl; wr_en = we;
        tb_en = 1; tb_drv = d;
        @(negedge clk);
        idle();
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        strobe_write(a, d, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic do_read(input logic [6:0] a, output logic [15:0] v);
        @(negedge clk);
        chip_sel = 1; cyc_start = 1; addr = a;
        @(negedge clk);
        cyc_start = 0; addr = ~a; wl_en = 1; sense_en = 1;
        @(negedge clk);
        wl_en = 0; sense_en = 0; out_en = 1;
        #1 v = data_io;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        chip_sel = 1; out_en = 1;
        #1 v = data_io;
        check("R1 reset latch", v, 16'h0000);
        idle();
    endtask

    task automatic t_basic();
        logic [15:0] v;
        do_write(7'd5, 16'hA55A);
        do_read(7'd5, v);
        check("R2 readback", v, 16'hA55A);
        do_write(7'd127, 16'h00FF);
        do_read(7'd127, v);
        check("R2 low half only", v, 16'h00FF);
        do_write(7'd0, 16'hC300);
        do_read(7'd0, v);
        check("R2 high half only", v, 16'hC300);
    endtask

    task automatic t_addr_hold();
        logic [15:0] v;
        // strobe_write puts ~a on the pins after capture; preload that address
        do_write(~7'd9, 16'h1234);
        do_write(7'd9, 16'hBEEF);
        do_read(7'd9, v);
        check("R3 captured address used", v, 16'hBEEF);
        do_read(~7'd9, v);
        check("R3 pin address untouched", v, 16'h1234);
    endtask

    task automatic t_gating();
        logic [15:0] v;
        do_write(7'd40, 16'h1111);
        strobe_write(7'd40, 16'h2222, 1'b1, 1'b0, 1'b1);
        do_read(7'd40, v);
        check("R4 we without wl", v, 16'h1111);
        strobe_write(7'd40, 16'h3333, 1'b1, 1'b1, 1'b0);
        do_read(7'd40, v);
        check("R4 wl without we", v, 16'h1111);
        strobe_write(7'd40, 16'h4444, 1'b0, 1'b1, 1'b1);
        do_read(7'd40, v);
        check("R8 chip select low blocks write", v, 16'h1111);
    endtask

    task automatic t_hold();
        logic [15:0] v;
        do_write(7'd60, 16'h6060);
        do_write(7'd61, 16'h6161);
        do_read(7'd60, v);
        @(negedge clk);
        chip_sel = 1; cyc_start = 1; addr = 7'd61;
        @(negedge clk);
        cyc_start = 0; wl_en = 1;
        @(negedge clk);
        wl_en = 0; out_en = 1;
        #1 v = data_io;
        check("R6 latch holds without sense", v, 16'h6060);
        @(negedge clk);
        wr_en = 1; sense_en = 1; out_en = 0;
        @(negedge clk);
        wr_en = 0; sense_en = 0; out_en = 1;
        #1 v = data_io;
        check("R6 sense ignored while writing", v, 16'h6060);
        @(negedge clk);
        idle();
    endtask

    task automatic t_bus();
        logic [15:0] v;
        do_write(7'd70, 16'h0F0F);
        do_read(7'd70, v);
        @(negedge clk);
        chip_sel = 0; out_en = 1; tb_en = 1; tb_drv = 16'h5A5A;
        #1 v = data_io;
        check("R5 released with chip select low", v, 16'h5A5A);
        @(negedge clk);
        chip_sel = 1; out_en = 0; tb_drv = 16'hA5A5;
        #1 v = data_io;
        check("R5 released with out_en low", v, 16'hA5A5);
        @(negedge clk);
        tb_en = 0; out_en = 1;
        #1 v = data_io;
        check("R5 driven when enabled", v, 16'h0F0F);
        @(negedge clk);
        idle();
    endtask

    task automatic t_groups();
        logic [15:0] v;
        for (int g = 0; g < 4; g++) do_write(7'd12 + 7'(g), 16'h1000 * 16'(g + 1) + 16'h00A0 + 16'(g));
        do_write(7'd16, 16'h7777);
        do_write(7'd8, 16'h8888);
        for (int g = 0; g < 4; g++) begin
            do_read(7'd12 + 7'(g), v);
            check("R7 column group", v, 16'h1000 * 16'(g + 1) + 16'h00A0 + 16'(g));
        end
        do_read(7'd16, v);
        check("R7 next row", v, 16'h7777);
        do_read(7'd8, v);
        check("R7 previous row", v, 16'h8888);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        addr = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_addr_hold();
        t_gating();
        t_hold();
        t_bus();
        t_groups();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule